// File: doc/BRIEF.md
# Two-Stage Prescaled Countdown Timer

This block is a periodic interval timer built from two cascaded down-counters. A 16-bit prescale stage counts system clocks and, each time it passes zero, reloads from a divide-down value and sends one tick to a 32-bit main stage. The main stage counts those ticks. When it passes zero, it reloads from a period value and raises a one-cycle interrupt pulse. The interval between pulses is therefore (period + 1) × (divide + 1) clock cycles.

Software programs the block through a write-only register port. Three locations are decoded: the 32-bit period, the 16-bit divide-down value, and a control word. The control word holds a sticky stop bit and two command bits, reload and flag-clear, which act only on the cycle of the write. A sticky flag records every interrupt pulse until software clears it. Both counter values are brought out so that other logic can read them.

Top module: `prescale_timer`

## Requirements
- R1: After reset the period register is all ones, the divide-down register is zero, the timer is stopped, count_o is all ones, presc_o is zero, and irq_o and flag_o are low.
- R2: While the timer runs, the prescale counter decreases by one every clock. On the clock where it is zero, it reloads the divide-down value and issues one tick, so it ticks once every divide + 1 clocks.
- R3: The main counter changes only on a prescaler tick, a reload command or reset. A tick decreases it by one.
- R4: A tick that arrives while the main counter is zero reloads the counter from the period register. irq_o is then high for the one cycle after that clock edge. With period P and divide D, the pulses are (P+1)(D+1) cycles apart, and they are continuous when P = D = 0.
- R5: While the stop bit is 1, both counters hold their values and no pulse occurs.
- R6: A reload command loads the period into the main counter and the divide-down value into the prescale counter on the same edge. It takes priority over counting, works while the timer is stopped, and produces no pulse.
- R7: flag_o goes high in the cycle after each irq_o pulse and stays high until a control write with the clear bit set. If a pulse and a clear coincide, the pulse wins.
- R8: Writing the period or divide-down register leaves both counters untouched. The new values are used at the next reload or underflow.
- R9: The register map is as follows. Address 0 is the period. Address 1 is the divide-down value, taken from data bits 15:0. Address 2 is the control word: bit 0 stop (sticky), bit 1 reload command, bit 2 flag clear. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| count_o | output | 32 | Current main counter value |
| presc_o | output | 16 | Current prescale counter value |
| irq_o | output | 1 | One-cycle interrupt pulse |
| flag_o | output | 1 | Sticky interrupt flag |

## Verification
A control write that starts the timer, or a write that loads the counters, takes effect on the edge that captures the write. Counting begins on the edge after that. For a start at edge N, the first pulse is therefore visible in the cycle after edge N + (P+1)(D+1), and the flag follows one cycle later. The driver computes each pulse's edge index from the formula and queues it. The monitor compares that index against a free-running edge counter, sampling on the falling clock edge so that every registered result has settled. Direct counter checks are placed at edge offsets worked out by hand from the same rules.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIVIDE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;

  localparam int unsigned CTRL_STOP   = 0;
  localparam int unsigned CTRL_RELOAD = 1;
  localparam int unsigned CTRL_CLEAR  = 2;
endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  period_o,
  output logic [PRE_W-1:0]  divide_o,
  output logic              stop_o,
  output logic              reload_o,
  output logic              clear_o
);
  logic ctrl_wr;

  assign ctrl_wr  = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign reload_o = ctrl_wr && wr_data_i[CTRL_RELOAD];
  assign clear_o  = ctrl_wr && wr_data_i[CTRL_CLEAR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o <= '1;
      divide_o <= '0;
      stop_o   <= 1'b1;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_PERIOD: period_o <= wr_data_i;
        ADDR_DIVIDE: divide_o <= wr_data_i[PRE_W-1:0];
        ADDR_CTRL:   stop_o   <= wr_data_i[CTRL_STOP];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int unsigned PRE_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic [PRE_W-1:0] divide_i,
  output logic [PRE_W-1:0] presc_o,
  output logic             tick_o
);
  logic at_zero;

  assign at_zero = (presc_o == '0);
  assign tick_o  = run_i && !reload_i && at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       presc_o <= '0;
    else if (reload_i) presc_o <= divide_i;
    else if (run_i)    presc_o <= at_zero ? divide_i : presc_o - 1'b1;
  end

  a_r5_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !reload_i) |=> $stable(presc_o));
  a_r2_reload_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (presc_o == $past(divide_i)));
endmodule

// File: rtl/ptmr_main.sv
module ptmr_main #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  logic underflow;

  // tick_i is already masked by a reload command
  assign underflow = tick_i && (count_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '1;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= underflow;
      if (reload_i || underflow) count_o <= period_i;
      else if (tick_i)           count_o <= count_o - 1'b1;
    end
  end

  a_r3_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !reload_i) |=> $stable(count_o));
  a_r4_irq_reloads_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (count_o == $past(period_i)));
endmodule

// File: rtl/prescale_timer.sv
module prescale_timer
  import ptmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [PRE_W-1:0]  presc_o,
  output logic              irq_o,
  output logic              flag_o
);
  logic [CNT_W-1:0] period;
  logic [PRE_W-1:0] divide;
  logic             stop, reload, clear, tick;

  ptmr_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .period_o(period), .divide_o(divide), .stop_o(stop),
    .reload_o(reload), .clear_o(clear)
  );

  ptmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .run_i(!stop), .reload_i(reload),
    .divide_i(divide), .presc_o(presc_o), .tick_o(tick)
  );

  ptmr_main #(.CNT_W(CNT_W)) u_main (
    .clk_i, .rst_ni, .tick_i(tick), .reload_i(reload),
    .period_i(period), .count_o(count_o), .irq_o(irq_o)
  );

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= irq_o || (flag_o && !clear);
  end

  a_r7_flag_after_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> flag_o);
  a_r6_reload_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> !irq_o);
endmodule

// File: tb/prescale_timer_test.sv
module prescale_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] count;
  logic [15:0] presc;
  logic        irq, flag;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  int last_edge = 0;
  int exp_q[$];

  prescale_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .count_o(count), .presc_o(presc),
    .irq_o(irq), .flag_o(flag)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at edge %0d", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  // one write, captured at the next rising edge; last_edge holds its index
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    last_edge = cyc;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // driver side: queue the edge indices of n pulses from a start at edge s
  task automatic expect_irqs(input int s, input int p, input int d, input int n);
    for (int k = 1; k <= n; k++) exp_q.push_back(s + k * (p + 1) * (d + 1));
  endtask

  // monitor: every pulse must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && irq) begin
      if (exp_q.size() == 0) check("R4 unexpected irq edge", cyc, 32'hffff_ffff);
      else check("R4 irq edge", cyc, exp_q.pop_front());
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int n, t, u;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count reset", count, 32'hffff_ffff);
    check("R1 presc reset", presc, 16'h0);
    check("R1 irq reset", irq, 0);
    check("R1 flag reset", flag, 0);

    // reload with reset register values, stay stopped
    wr(2'd2, 32'h3);
    check("R1 R6 period reset all ones", count, 32'hffff_ffff);
    check("R1 R6 divide reset zero", presc, 16'h0);
    repeat (5) @(negedge clk);
    check("R1 R5 stopped after reset", count, 32'hffff_ffff);

    // P=3 D=2, reload and run in one write
    wr(2'd1, 32'h2);
    wr(2'd0, 32'h3);
    wr(2'd2, 32'h2);
    n = last_edge;
    expect_irqs(n, 3, 2, 3);
    check("R6 reload main", count, 3);
    check("R6 reload presc", presc, 2);
    @(negedge clk);
    check("R2 presc decrements", presc, 1);
    check("R3 main holds without tick", count, 3);
    wait_until(n + 3);
    check("R3 main decrements on tick", count, 2);
    check("R2 presc reloads divide", presc, 2);
    wait_until(n + 38);
    check("R4 all pulses seen", exp_q.size(), 0);
    check("R7 flag sticky", flag, 1);

    // stop and reload together, then clear the flag while stopped
    wr(2'd2, 32'h3);
    check("R6 reload while stopping", count, 3);
    wr(2'd2, 32'h5);
    check("R7 flag cleared", flag, 0);
    repeat (20) @(negedge clk);
    check("R5 main holds", count, 3);
    check("R5 presc holds", presc, 2);
    check("R7 flag stays clear", flag, 0);

    // new period/divide while stopped: counters untouched
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h0);
    check("R8 main untouched", count, 3);
    check("R8 presc untouched", presc, 2);

    // run without reload: 3 prescale clocks, 3 more ticks, then every 2
    wr(2'd2, 32'h0);
    t = last_edge;
    exp_q.push_back(t + 6);
    exp_q.push_back(t + 8);
    exp_q.push_back(t + 10);
    wait_until(t + 10);
    wr(2'd2, 32'h3);
    check("R4 R8 pulses with new values", exp_q.size(), 0);
    check("R6 reload main stopped", count, 1);
    check("R6 reload presc stopped", presc, 0);
    @(negedge clk);
    check("R6 no irq after reload", irq, 0);

    // unmapped address ignored
    wr(2'd3, 32'hffff_fffe);
    repeat (4) @(negedge clk);
    check("R9 addr 3 ignored main", count, 1);
    check("R9 addr 3 ignored presc", presc, 0);

    // P=0 D=0: pulse on every cycle
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h2);
    u = last_edge;
    for (int k = 1; k <= 5; k++) exp_q.push_back(u + k);
    wait_until(u + 5);
    wr(2'd2, 32'h3);
    check("R4 continuous pulses", exp_q.size(), 0);
    check("R6 no irq on reload", irq, 0);
    check("R7 flag after pulses", flag, 1);

    repeat (3) @(negedge clk);
    check("R4 no stray pulses", exp_q.size(), 0);
    summary();
  end
endmodule